// File: doc/BRIEF.md
# Capture, Compare and Pulse-Width Unit

One timer channel that works in one of three ways. In capture modes it watches an input pin and copies a free-running timebase into its 16-bit holding register when a chosen pin event occurs. The event can be a falling edge, a rising edge, or every fourth or sixteenth rising edge. In compare modes it watches the same timebase until it equals the holding register. On that match it sets the pin, clears the pin, raises only an event, or raises an event together with a trigger pulse for other blocks. In PWM mode it builds a 10-bit duty value from the low byte of the holding register and two fine bits in the control register. It drives the pin from an external period timer and that timer's two prescaler bits.

The timebase, the period timer, its prescaler state and its period-match pulse all come from outside the block. Software-side access is limited to three byte-write strobes: low byte, high byte and control. The holding register is visible on an output. The control byte carries the mode in bits 3:0 and the fine duty bits in bits 5:4.

Top module: `ccp_unit`

## Requirements
- R1: After synchronous reset the control register is 0 (unit off), the holding register reads 0, and pin_o, irq_o and trig_o are low. While off, pin activity and timebase matches produce no event.
- R2: Mode 0100 captures on each falling edge of pin_i and mode 0101 on each rising edge. An edge is a pin_i value that differs from the value at the previous clock edge. The holding register takes the timebase present on the clock edge that first sees the new pin level. irq_o pulses for one cycle on the following cycle.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Each capture raises one irq_o pulse.
- R4: Every control write clears the capture edge counter, so edges counted before the write do not count toward the next capture.
- R5: Writing mode 1000 drives pin_o low and a match then drives it high. Writing mode 1001 drives pin_o high and a match then drives it low.
- R6: In compare modes (10xx) a match occurs on the first cycle the timebase equals the holding register. A timebase that stays equal gives no further match. Each match gives one irq_o pulse on the next cycle.
- R7: Mode 1010 raises only irq_o and leaves pin_o low. Mode 1011 pulses trig_o together with irq_o.
- R8: Modes 1100 to 1111 select PWM. On a period-match pulse pin_o goes high on the next cycle and the duty value {holding[7:0], control[5:4]} is latched.
- R9: In PWM mode pin_o goes low after the clock edge on which {ptmr_i, pfine_i} equals the latched duty. With the count advancing once per clock, the pin is high for duty+1 cycles per period, or the whole period if the duty exceeds the period. A duty change takes effect only at the next period match.
- R10: PWM modes and the reserved modes 0001 to 0011 never pulse irq_o. The reserved modes act as off.
- R11: A capture wins over a byte write to the holding register in the same cycle. Without a capture, a byte write updates only its own byte.
- R12: pin_o is low in the off, reserved and capture modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | 16 | Timebase value for capture and compare |
| ptmr_i | input | 8 | Period timer count |
| pfine_i | input | 2 | Period timer prescaler bits, low end of the 10-bit PWM count |
| pmatch_i | input | 1 | Period timer equals its period register |
| pin_i | input | 1 | Capture pin |
| wdata_i | input | 8 | Write data |
| wr_lo_i | input | 1 | Write holding register low byte |
| wr_hi_i | input | 1 | Write holding register high byte |
| wr_ctl_i | input | 1 | Write control (bits 5:0) |
| ccpr_o | output | 16 | Holding register value |
| pin_o | output | 1 | Output pin |
| irq_o | output | 1 | One-cycle event pulse |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench uses the default widths: a 16-bit timebase and an 8-bit period timer with 2 fine bits. It can freeze or step the timebase, so captured values and held-equal matches can be checked exactly. It generates the period timer with a period value of 9, which makes a PWM period 40 clocks long. Several full periods therefore fit in each window, and duties of 0, mid-range and above the period can all be measured as whole high-cycle counts.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int FINE_W = 2;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        KIND_OFF = 2'd0,
        KIND_CAP = 2'd1,
        KIND_CMP = 2'd2,
        KIND_PWM = 2'd3
    } kind_e;

    // compare actions, taken from mode bits 1:0
    typedef enum logic [1:0] {
        ACT_SET  = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_IRQ  = 2'd2,
        ACT_TRIG = 2'd3
    } act_e;

    typedef struct packed {
        logic [FINE_W-1:0] fine;
        logic [MODE_W-1:0] mode;
    } ctl_t;

    function automatic kind_e kind_of(input logic [MODE_W-1:0] m);
        case (m[3:2])
            2'b11:   return KIND_PWM;
            2'b10:   return KIND_CMP;
            2'b01:   return KIND_CAP;
            default: return KIND_OFF;
        endcase
    endfunction

    // number of qualifying pin edges per capture
    function automatic logic [4:0] cap_div(input logic [1:0] sel);
        case (sel)
            2'b10:   return 5'd4;
            2'b11:   return 5'd16;
            default: return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       pin_i,
    output logic       evt
);

    logic             pin_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             last;

    // sel 00 watches falling edges, the rest rising edges
    assign hit  = (sel == 2'b00) ? (pin_q & ~pin_i) : (~pin_q & pin_i);
    assign last = (cnt_q == CNT_W'(cap_div(sel) - 5'd1));
    assign evt  = en & ~clr & hit & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pin_q <= pin_i;
            if (!en || clr)
                cnt_q <= '0;
            else if (hit)
                cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] tbase,
    input  logic [W-1:0] cmp_val,
    output logic         evt
);

    logic eq;
    logic eq_q;

    assign eq  = (tbase == cmp_val);
    assign evt = en & eq & ~eq_q;

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          pmatch,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] duty,
    output logic          out
);

    logic [DW-1:0] duty_q;
    logic          out_q;

    assign out = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            out_q  <= 1'b0;
        end else if (!en) begin
            out_q <= 1'b0;
        end else if (pmatch) begin
            out_q  <= 1'b1;
            duty_q <= duty;
        end else if (count == duty_q) begin
            out_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int TB_W  = 16,
    parameter int PT_W  = 8,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TB_W-1:0]    tbase_i,
    input  logic [PT_W-1:0]    ptmr_i,
    input  logic [FINE_W-1:0]  pfine_i,
    input  logic               pmatch_i,
    input  logic               pin_i,
    input  logic [TB_W/2-1:0]  wdata_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic               wr_ctl_i,
    output logic [TB_W-1:0]    ccpr_o,
    output logic               pin_o,
    output logic               irq_o,
    output logic               trig_o
);

    localparam int HALF   = TB_W / 2;
    localparam int DUTY_W = PT_W + FINE_W;
    localparam int CTL_W  = FINE_W + MODE_W;

    ctl_t            ctl_q;
    ctl_t            ctl_new;
    kind_e           kind;
    act_e            act;
    logic [TB_W-1:0] ccpr_q;
    logic            cmp_q;
    logic            irq_q;
    logic            trig_q;
    logic            cap_evt;
    logic            cmp_evt;
    logic            pwm_out;

    assign ctl_new = ctl_t'(wdata_i[CTL_W-1:0]);
    assign kind    = kind_of(ctl_q.mode);
    assign act     = act_e'(ctl_q.mode[1:0]);

    ccp_capture #(.CNT_W(CNT_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .en    (kind == KIND_CAP),
        .clr   (wr_ctl_i),
        .sel   (ctl_q.mode[1:0]),
        .pin_i (pin_i),
        .evt   (cap_evt)
    );

    ccp_compare #(.W(TB_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .en      ((kind == KIND_CMP) && !wr_ctl_i),
        .tbase   (tbase_i),
        .cmp_val (ccpr_q),
        .evt     (cmp_evt)
    );

    ccp_pwm #(.DW(DUTY_W)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .en     (kind == KIND_PWM),
        .pmatch (pmatch_i),
        .count  ({ptmr_i, pfine_i}),
        .duty   ({ccpr_q[PT_W-1:0], ctl_q.fine}),
        .out    (pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ccpr_q <= '0;
            cmp_q  <= 1'b0;
            irq_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            if (wr_ctl_i)
                ctl_q <= ctl_new;

            if (cap_evt) begin
                ccpr_q <= tbase_i;
            end else begin
                if (wr_lo_i) ccpr_q[HALF-1:0]    <= wdata_i;
                if (wr_hi_i) ccpr_q[TB_W-1:HALF] <= wdata_i;
            end

            if (wr_ctl_i)
                cmp_q <= (kind_of(ctl_new.mode) == KIND_CMP) &&
                         (act_e'(ctl_new.mode[1:0]) == ACT_CLR);
            else if (cmp_evt && act == ACT_SET)
                cmp_q <= 1'b1;
            else if (cmp_evt && act == ACT_CLR)
                cmp_q <= 1'b0;

            irq_q  <= cap_evt | cmp_evt;
            trig_q <= cmp_evt && (act == ACT_TRIG);
        end
    end

    always_comb begin
        case (kind)
            KIND_PWM: pin_o = pwm_out;
            KIND_CMP: pin_o = cmp_q;
            default:  pin_o = 1'b0;
        endcase
    end

    assign ccpr_o = ccpr_q;
    assign irq_o  = irq_q;
    assign trig_o = trig_q;

endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
    parameter int TB_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      mode,
    input logic            cap_evt,
    input logic [TB_W-1:0] ccpr,
    input logic [TB_W-1:0] tbase_i,
    input logic            wr_lo_i,
    input logic            wr_hi_i,
    input logic            wr_ctl_i,
    input logic            pmatch_i,
    input logic            pin_o,
    input logic            irq_o,
    input logic            trig_o
);

    p_cap_value_r2: assert property (@(posedge clk) disable iff (rst)
        $past(cap_evt) |-> (ccpr == $past(tbase_i)));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_trig_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> irq_o);

    p_pwm_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $past(pmatch_i && (mode[3:2] == 2'b11) && !wr_ctl_i) |-> pin_o);

    p_pwm_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(mode[3:2] == 2'b11) |-> !irq_o);

    p_ccpr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(cap_evt) && !$past(wr_lo_i) && !$past(wr_hi_i)) |-> $stable(ccpr));

endmodule

bind ccp_unit ccp_unit_chk #(.TB_W(TB_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (ctl_q.mode),
    .cap_evt  (cap_evt),
    .ccpr     (ccpr_q),
    .tbase_i  (tbase_i),
    .wr_lo_i  (wr_lo_i),
    .wr_hi_i  (wr_hi_i),
    .wr_ctl_i (wr_ctl_i),
    .pmatch_i (pmatch_i),
    .pin_o    (pin_o),
    .irq_o    (irq_o),
    .trig_o   (trig_o)
);

// File: tb/sim_ccp_unit.sv
`timescale 1ns/1ps
module sim_ccp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tbase_i = '0;
    logic [7:0]  ptmr_i = '0;
    logic [1:0]  pfine_i = '0;
    logic        pmatch_i = 1'b0;
    logic        pin_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic        wr_lo_i = 1'b0, wr_hi_i = 1'b0, wr_ctl_i = 1'b0;
    logic [15:0] ccpr_o;
    logic        pin_o, irq_o, trig_o;

    int n_run = 0, n_fail = 0;
    bit tb_inc = 0, pwm_run = 0, done = 0;
    int pcount = 0;
    localparam int PLAST = 39;   // period value 9 -> 40 fine counts

    int irq_cnt = 0, trig_cnt = 0, hi_cnt = 0;

    // behavioural reference state
    int m_ctl = 0, m_ccpr = 0, m_cnt = 0, m_dl = 0;
    bit m_pinq = 0, m_eq = 0, m_cmpo = 0, m_pwmo = 0, m_irq = 0, m_trig = 0;

    always #2.5 clk = ~clk;

    ccp_unit u0 (
        .clk(clk), .rst(rst), .tbase_i(tbase_i), .ptmr_i(ptmr_i),
        .pfine_i(pfine_i), .pmatch_i(pmatch_i), .pin_i(pin_i),
        .wdata_i(wdata_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
        .wr_ctl_i(wr_ctl_i), .ccpr_o(ccpr_o), .pin_o(pin_o),
        .irq_o(irq_o), .trig_o(trig_o)
    );

    // timebase and period-timer stimulus
    always @(posedge clk) begin
        #2;
        if (tb_inc) tbase_i <= tbase_i + 16'd1;
        if (pwm_run) begin
            pcount = (pcount == PLAST) ? 0 : pcount + 1;
            ptmr_i   <= 8'(pcount >> 2);
            pfine_i  <= 2'(pcount & 3);
            pmatch_i <= (pcount == PLAST);
        end
    end

    // reference model, updated on the clock edge
    always @(posedge clk) begin
        int md, dv, t, c;
        bit fall, rise, hit, cap_ev, cmp_ev, eq, w;
        if (rst) begin
            m_ctl = 0; m_ccpr = 0; m_cnt = 0; m_dl = 0;
            m_pinq = 0; m_eq = 0; m_cmpo = 0; m_pwmo = 0; m_irq = 0; m_trig = 0;
        end else begin
            md = m_ctl % 16;
            w = wr_ctl_i;
            t = int'(tbase_i);
            fall = m_pinq && !pin_i;
            rise = !m_pinq && pin_i;
            cap_ev = 0;
            if (md >= 4 && md <= 7 && !w) begin
                dv = (md == 6) ? 4 : (md == 7) ? 16 : 1;
                hit = (md == 4) ? fall : rise;
                if (hit) begin
                    if (m_cnt == dv - 1) begin cap_ev = 1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end else m_cnt = 0;
            m_pinq = pin_i;
            eq = (t == m_ccpr);
            cmp_ev = (md >= 8 && md <= 11) && !w && eq && !m_eq;
            m_eq = eq;
            c = int'(ptmr_i) * 4 + int'(pfine_i);
            if (md < 12) m_pwmo = 0;
            else if (pmatch_i) begin m_pwmo = 1; m_dl = (m_ccpr % 256) * 4 + (m_ctl / 16) % 4; end
            else if (c == m_dl) m_pwmo = 0;
            if (w) m_cmpo = (int'(wdata_i) % 16 == 9);
            else if (cmp_ev && md == 8) m_cmpo = 1;
            else if (cmp_ev && md == 9) m_cmpo = 0;
            if (cap_ev) m_ccpr = t;
            else begin
                if (wr_lo_i) m_ccpr = (m_ccpr / 256) * 256 + int'(wdata_i);
                if (wr_hi_i) m_ccpr = int'(wdata_i) * 256 + m_ccpr % 256;
            end
            m_irq = cap_ev || cmp_ev;
            m_trig = cmp_ev && md == 11;
            if (w) m_ctl = int'(wdata_i) % 64;
        end
    end

    function automatic string tag_of(int ctl);
        int md = ctl % 16;
        if (md >= 12) return "R9";
        if (md >= 8)  return "R5";
        if (md >= 4)  return "R2";
        return "R1";
    endfunction

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        bit exp_pin;
        int md;
        if (!rst && !done) begin
            md = m_ctl % 16;
            exp_pin = (md >= 12) ? m_pwmo : (md >= 8) ? m_cmpo : 1'b0;
            n_run++;
            if (int'(ccpr_o) != m_ccpr || pin_o != exp_pin || irq_o != m_irq || trig_o != m_trig) begin
                n_fail++;
                $display("FAIL %s model: ccpr=%h/%h pin=%0d/%0d irq=%0d/%0d trig=%0d/%0d (act/exp)",
                         tag_of(m_ctl), ccpr_o, m_ccpr[15:0], pin_o, exp_pin, irq_o, m_irq, trig_o, m_trig);
            end
            if (irq_o) irq_cnt++;
            if (trig_o) trig_cnt++;
            if (pin_o) hi_cnt++;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic put_ctl(int v);
        wdata_i = 8'(v); wr_ctl_i = 1; tick(); wr_ctl_i = 0;
    endtask

    task automatic put_ccpr(int v);
        wdata_i = 8'(v % 256); wr_lo_i = 1; tick(); wr_lo_i = 0;
        wdata_i = 8'(v / 256); wr_hi_i = 1; tick(); wr_hi_i = 0;
    endtask

    task automatic pulses(int n);
        repeat (n) begin pin_i = 1; tick(2); pin_i = 0; tick(2); end
    endtask

    task automatic clear_counts();
        irq_cnt = 0; trig_cnt = 0; hi_cnt = 0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        report();
        $finish;
    end

    initial begin
        tick(4);
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 ccpr", int'(ccpr_o), 0);
        chk("R1 pin", int'(pin_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        tb_inc = 1;
        clear_counts();
        pulses(4);
        tick(3);
        chk("R1 off no events", irq_cnt, 0);

        // R2 falling edges, exact value with a frozen timebase
        put_ctl(8'h04);
        pin_i = 1; tick(2);
        tb_inc = 0; tick(2);
        tbase_i = 16'hBEEF; pin_i = 0; tick(3);
        chk("R2 falling capture value", int'(ccpr_o), 16'hBEEF);
        clear_counts();
        tb_inc = 1;
        pulses(3); tick(2);
        chk("R2 falling count", irq_cnt, 3);
        put_ctl(8'h05);
        clear_counts();
        pulses(3); tick(2);
        chk("R2 rising count", irq_cnt, 3);
        chk("R12 pin low in capture", int'(pin_o), 0);

        // R3 prescaled capture
        put_ctl(8'h06); clear_counts();
        pulses(8); tick(2);
        chk("R3 every 4th", irq_cnt, 2);
        put_ctl(8'h07); clear_counts();
        pulses(20); tick(2);
        chk("R3 every 16th", irq_cnt, 1);

        // R4 control write clears edge counter
        put_ctl(8'h06); clear_counts();
        pulses(3);
        put_ctl(8'h06);
        pulses(3); tick(2);
        chk("R4 counter cleared", irq_cnt, 0);
        pulses(1); tick(2);
        chk("R4 fourth edge after write", irq_cnt, 1);

        // R11 capture beats a byte write in the same cycle
        put_ctl(8'h04);
        pin_i = 1; tick(2);
        tb_inc = 0; tick(2);
        tbase_i = 16'h1234; pin_i = 0; wdata_i = 8'h55; wr_lo_i = 1; tick(); wr_lo_i = 0;
        tick(2);
        chk("R11 capture wins", int'(ccpr_o), 16'h1234);
        put_ctl(8'h00);
        wdata_i = 8'hA7; wr_hi_i = 1; tick(); wr_hi_i = 0; tick();
        chk("R11 high byte only", int'(ccpr_o), 16'hA734);

        // R5/R6 compare set
        tbase_i = 16'd100;
        put_ccpr(16'h0110);
        put_ctl(8'h08); tick();
        chk("R5 set mode starts low", int'(pin_o), 0);
        clear_counts();
        tb_inc = 1; tick(200);
        chk("R5 set on match", int'(pin_o), 1);
        chk("R6 one match", irq_cnt, 1);

        // R5 compare clear
        tb_inc = 0; tbase_i = 16'd0;
        put_ccpr(16'h0020);
        put_ctl(8'h09); tick();
        chk("R5 clear mode starts high", int'(pin_o), 1);
        clear_counts();
        tb_inc = 1; tick(50);
        chk("R5 cleared on match", int'(pin_o), 0);
        chk("R6 clear one match", irq_cnt, 1);

        // R6/R7 event-only mode with a held-equal timebase
        tb_inc = 0; tbase_i = 16'h0040;
        put_ctl(8'h0A);
        put_ccpr(16'h0050);
        clear_counts();
        tbase_i = 16'h0050; tick(10);
        chk("R6 held equal fires once", irq_cnt, 1);
        chk("R7 event-only leaves pin low", int'(pin_o), 0);

        // R7 trigger mode
        tbase_i = 16'd0;
        put_ccpr(16'h0008);
        put_ctl(8'h0B);
        clear_counts();
        tb_inc = 1; tick(20);
        chk("R7 trigger pulse", trig_cnt, 1);
        chk("R7 trigger with irq", irq_cnt, 1);

        // R10 reserved mode acts as off
        tb_inc = 0; tbase_i = 16'd0;
        put_ctl(8'h02);
        put_ccpr(16'h0004);
        clear_counts();
        tb_inc = 1;
        pulses(4); tick(2);
        chk("R10 reserved no irq", irq_cnt, 0);
        chk("R12 reserved pin low", int'(pin_o), 0);

        // R8/R9 PWM
        tb_inc = 0;
        pwm_run = 1;
        put_ccpr(16'h0003);
        put_ctl(8'h2C);                 // fine 2 -> duty 14
        tick(80); clear_counts(); tick(120);
        chk("R8 duty 14 high cycles", hi_cnt, 45);
        chk("R10 pwm no irq", irq_cnt, 0);
        put_ccpr(16'h0000);
        put_ctl(8'h0F);                 // other PWM code, duty 0
        tick(80); clear_counts(); tick(120);
        chk("R9 duty 0 high cycles", hi_cnt, 3);
        put_ccpr(16'h0014);             // duty 80 exceeds period
        tick(80); clear_counts(); tick(120);
        chk("R9 duty above period", hi_cnt, 120);
        put_ccpr(16'h0005);             // mid-period change, model checks deferral
        tick(100);

        done = 1;
        report();
        $finish;
    end

endmodule